// File: doc/BRIEF.md
# Reference-Locked Oscillator Control Loop with Fractional Tap Modulator

This block keeps a free-running, digitally tuned oscillator at a programmable multiple of a slower, stable reference clock. The oscillator's own clock drives a counter that measures how many oscillator cycles fit into each reference period. The reference domain compares that measurement with a target built from a 7-bit multiplier, a 2-bit power-of-two divider select and a bypass bit. Once per reference period it moves a 10-bit frequency integrator one step up or one step down. The integrator saturates at both ends, and a clear input drops it back to zero.

The integrator's upper five bits pick a coarse oscillator tap, clamped at 28. Its lower five bits are a fractional value. A modulator running on the oscillator clock spreads exactly that many "tap plus one" cycles evenly over every 32 oscillator cycles. The analog oscillator stays outside the block: it receives `tap_code` and `tap_up` each cycle and returns its clock on `dco_clk`.

The measurement passes from the oscillator domain to the reference domain as a held count and a toggle through a two-flop synchronizer. The integrator goes back to the modulator the same way. The first complete reference period after reset only arms the counter, so no partial count ever steers the loop. The ratio inputs are registered on every reference edge, so a change governs the comparisons of the following periods. The reset `rst` is synchronous and active high, and it must stay high across several edges of both clocks.

Top module: `fll_dco_ctrl`

## Requirements
- R1: With `rst` high at an edge, `integ_value` reads 0 after that reference edge, and `tap_code` and `tap_up` read 0 after that oscillator edge.
- R2: The target is T = N+1 when `ratio_bypass` is 0 and T = (N+1)·2^dsel when it is 1, where dsel values 0, 1, 2 and 3 mean ×1, ×2, ×4 and ×8. Each reference period the integrator steps up when the oscillator cycles counted in the last complete reference period are fewer than T, and steps down otherwise.
- R3: Once the loop is running, `integ_value` changes by exactly one per reference period and never by more than one at a reference edge, except when cleared.
- R4: The integrator saturates: stepping up at 1023 leaves 1023, and stepping down at 0 leaves 0.
- R5: `integ_clr` high at a reference rising edge makes `integ_value` 0 after that edge, overriding any step. Stepping then resumes from 0.
- R6: `tap_code` equals `integ_value[9:5]` clamped to at most 28.
- R7: While the integrator is constant and its upper five bits are below 28, every 32 consecutive oscillator cycles contain exactly `integ_value[4:0]` cycles with `tap_up` high.
- R8: Under the same conditions, every 16 consecutive oscillator cycles contain floor(M/2) or ceil(M/2) cycles with `tap_up` high, where M = `integ_value[4:0]`.
- R9: While the integrator's upper five bits are 28 or more, `tap_up` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dco_clk | input | 1 | Clock returned by the tuned oscillator |
| ref_clk | input | 1 | Stable reference clock |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| ratio_mult | input | 7 | Multiplier field N; the target is N+1 times the reference |
| ratio_dsel | input | 2 | Divider select, factor 2^dsel |
| ratio_bypass | input | 1 | 1: divider factor joins the target; 0: target is N+1 |
| integ_clr | input | 1 | Reference-domain request that zeroes the integrator |
| integ_value | output | 10 | Frequency integrator, reference domain |
| tap_code | output | 5 | Coarse oscillator tap, 0 to 28 |
| tap_up | output | 1 | 1: use tap_code+1 in this oscillator cycle |

## Verification
The bench builds the block with its default widths: a 10-bit integrator split 5/5, a 7-bit multiplier and a 2-bit divider select. It runs the oscillator clock against reference periods of exactly 20 or exactly 200 oscillator cycles, so every measured count is known exactly. The short period sweeps every divider and bypass combination with multipliers on both sides of the measured count, and it makes a ramp to the 1023 ceiling affordable. The long period keeps each integrator value still for a hundred oscillator cycles, so the 32-cycle and 16-cycle `tap_up` windows can be counted for fractional values 0 to 31 and across the clamp at tap 28.

// File: rtl/fll_pkg.sv
`timescale 1ns/1ps
package fll_pkg;

    // Field widths of the loop
    localparam int INT_W    = 10;                   // frequency integrator
    localparam int TAP_W    = 5;                    // coarse tap field
    localparam int MOD_W    = INT_W - TAP_W;        // fractional field, frame = 2**MOD_W
    localparam int TAP_LAST = 28;                   // highest implemented tap
    localparam int MULT_W   = 7;                    // ratio multiplier
    localparam int DSEL_W   = 2;                    // divider select
    localparam int CNT_W    = MULT_W + (1 << DSEL_W); // holds largest target (N+1)<<max
    localparam int SYNC_N   = 2;                    // synchronizer depth

    typedef logic [INT_W-1:0] integ_t;
    typedef logic [TAP_W-1:0] tap_t;
    typedef logic [MOD_W-1:0] frac_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam integ_t INT_TOP = '1;
    localparam cnt_t   CNT_TOP = '1;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [DSEL_W-1:0] dsel;
        logic              bypass;
    } ratio_cfg_t;

    // Coarse field on top, fractional field below, matching the integrator bits
    typedef struct packed {
        tap_t  tap;
        frac_t frac;
    } integ_split_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_t;

    localparam ratio_cfg_t CFG_RESET = '{mult: MULT_W'(31), dsel: DSEL_W'(1), bypass: 1'b0};

    function automatic cnt_t target_count(ratio_cfg_t c);
        cnt_t base;
        base = cnt_t'(c.mult) + cnt_t'(1);
        return c.bypass ? (base << c.dsel) : base;
    endfunction

    function automatic cnt_t count_inc(cnt_t v);
        return (v == CNT_TOP) ? v : v + 1'b1;
    endfunction

    function automatic integ_t integ_step(integ_t v, step_dir_t d);
        if (d == DIR_UP) return (v == INT_TOP) ? v : v + 1'b1;
        return (v == '0) ? v : v - 1'b1;
    endfunction

    function automatic tap_t tap_clamp(tap_t t);
        return (t > tap_t'(TAP_LAST)) ? tap_t'(TAP_LAST) : t;
    endfunction

endpackage

// File: rtl/fll_period_counter.sv
`timescale 1ns/1ps
// Oscillator domain: counts oscillator cycles between synchronized reference
// rising edges and publishes each complete count with a toggle.
module fll_period_counter
    import fll_pkg::*;
(
    input  logic dco_clk,
    input  logic rst,
    input  logic ref_clk,
    output cnt_t period_cnt,
    output logic period_tog
);
    localparam int WARM_W = 2;
    localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(2);

    logic [SYNC_N:0]   ref_sync;
    cnt_t              run_cnt;
    logic [WARM_W-1:0] warm;
    logic              boundary;

    assign boundary = ref_sync[SYNC_N-1] & ~ref_sync[SYNC_N];

    always_ff @(posedge dco_clk) begin
        if (rst) begin
            ref_sync   <= '0;
            run_cnt    <= '0;
            warm       <= '0;
            period_cnt <= '0;
            period_tog <= 1'b0;
        end else begin
            ref_sync <= {ref_sync[SYNC_N-1:0], ref_clk};
            if (boundary) begin
                run_cnt <= '0;
                if (warm != WARM_DONE) begin
                    warm <= warm + 1'b1;
                end else begin
                    period_cnt <= count_inc(run_cnt);
                    period_tog <= ~period_tog;
                end
            end else begin
                run_cnt <= count_inc(run_cnt);
            end
        end
    end
endmodule

// File: rtl/fll_integrator.sv
`timescale 1ns/1ps
// Reference domain: compares each published count with the target and
// moves the integrator one step per period.
module fll_integrator
    import fll_pkg::*;
(
    input  logic       ref_clk,
    input  logic       rst,
    input  ratio_cfg_t cfg_in,
    input  logic       integ_clr,
    input  cnt_t       period_cnt,
    input  logic       period_tog,
    output integ_t     integ,
    output logic       upd_tog
);
    ratio_cfg_t      cfg_q;
    logic [SYNC_N:0] tog_sync;
    logic            evt;
    cnt_t            target;
    step_dir_t       dir;

    assign evt    = tog_sync[SYNC_N-1] ^ tog_sync[SYNC_N];
    assign target = target_count(cfg_q);
    assign dir    = (period_cnt < target) ? DIR_UP : DIR_DOWN;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            cfg_q    <= CFG_RESET;
            tog_sync <= '0;
            integ    <= '0;
            upd_tog  <= 1'b0;
        end else begin
            cfg_q    <= cfg_in;
            tog_sync <= {tog_sync[SYNC_N-1:0], period_tog};
            if (integ_clr) begin
                integ   <= '0;
                upd_tog <= ~upd_tog;
            end else if (evt) begin
                integ   <= integ_step(integ, dir);
                upd_tog <= ~upd_tog;
            end
        end
    end
endmodule

// File: rtl/fll_modulator.sv
`timescale 1ns/1ps
// Oscillator domain: picks up the integrator, applies it on frame
// boundaries and spreads tap+1 cycles with a phase accumulator.
module fll_modulator
    import fll_pkg::*;
(
    input  logic   dco_clk,
    input  logic   rst,
    input  integ_t integ,
    input  logic   upd_tog,
    output tap_t   tap_code,
    output logic   tap_up
);
    logic [SYNC_N:0] upd_sync;
    integ_split_t    held;
    integ_split_t    frame;
    frac_t           slot;
    frac_t           phase;
    logic [MOD_W:0]  phase_sum;
    logic            frame_end;
    logic            saturated;

    assign frame_end = (slot == '1);
    assign saturated = (frame.tap >= tap_t'(TAP_LAST));
    assign phase_sum = {1'b0, phase} + {1'b0, frame.frac};

    always_ff @(posedge dco_clk) begin
        if (rst) begin
            upd_sync <= '0;
            held     <= '0;
            frame    <= '0;
            slot     <= '0;
            phase    <= '0;
            tap_code <= '0;
            tap_up   <= 1'b0;
        end else begin
            upd_sync <= {upd_sync[SYNC_N-1:0], upd_tog};
            if (upd_sync[SYNC_N-1] ^ upd_sync[SYNC_N]) begin
                held <= integ_split_t'(integ);
            end
            slot <= slot + 1'b1;
            if (frame_end) begin
                frame <= held;
            end
            phase    <= phase_sum[MOD_W-1:0];
            tap_code <= tap_clamp(frame.tap);
            tap_up   <= phase_sum[MOD_W] & ~saturated;
        end
    end
endmodule

// File: rtl/fll_dco_ctrl.sv
`timescale 1ns/1ps
module fll_dco_ctrl
    import fll_pkg::*;
(
    input  logic              dco_clk,
    input  logic              ref_clk,
    input  logic              rst,
    input  logic [MULT_W-1:0] ratio_mult,
    input  logic [DSEL_W-1:0] ratio_dsel,
    input  logic              ratio_bypass,
    input  logic              integ_clr,
    output logic [INT_W-1:0]  integ_value,
    output logic [TAP_W-1:0]  tap_code,
    output logic              tap_up
);
    ratio_cfg_t cfg_in;
    cnt_t       period_cnt;
    logic       period_tog;
    integ_t     integ;
    logic       upd_tog;

    assign cfg_in = '{mult: ratio_mult, dsel: ratio_dsel, bypass: ratio_bypass};

    fll_period_counter u_counter (
        .dco_clk    (dco_clk),
        .rst        (rst),
        .ref_clk    (ref_clk),
        .period_cnt (period_cnt),
        .period_tog (period_tog)
    );

    fll_integrator u_integrator (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .cfg_in     (cfg_in),
        .integ_clr  (integ_clr),
        .period_cnt (period_cnt),
        .period_tog (period_tog),
        .integ      (integ),
        .upd_tog    (upd_tog)
    );

    fll_modulator u_modulator (
        .dco_clk  (dco_clk),
        .rst      (rst),
        .integ    (integ),
        .upd_tog  (upd_tog),
        .tap_code (tap_code),
        .tap_up   (tap_up)
    );

    assign integ_value = integ;
endmodule

// File: rtl/fll_dco_ctrl_chk.sv
`timescale 1ns/1ps
module fll_dco_ctrl_chk
    import fll_pkg::*;
(
    input logic             dco_clk,
    input logic             ref_clk,
    input logic             rst,
    input logic             integ_clr,
    input logic [INT_W-1:0] integ_value,
    input logic [TAP_W-1:0] tap_code,
    input logic             tap_up
);
    logic rst_seen_ref = 1'b0;
    logic rst_seen_dco = 1'b0;

    // R1: one edge after reset was sampled, the outputs are cleared
    always_ff @(posedge ref_clk) begin
        if (rst_seen_ref) begin
            assert_reset_integ_R1: assert (integ_value == '0);
        end
        rst_seen_ref <= rst;
    end

    always_ff @(posedge dco_clk) begin
        if (rst_seen_dco) begin
            assert_reset_tap_R1: assert (tap_code == '0 && !tap_up);
        end
        rst_seen_dco <= rst;
    end

    // R3 (and no wrap at the ends, R4): at most one unit per reference edge
    assert_unit_step_R3: assert property (@(posedge ref_clk) disable iff (rst)
        !$past(integ_clr) |->
            (int'(integ_value) - int'($past(integ_value)) <= 1) &&
            (int'($past(integ_value)) - int'(integ_value) <= 1));

    assert_clear_zero_R5: assert property (@(posedge ref_clk) disable iff (rst)
        $past(integ_clr) |-> integ_value == '0);

    assert_tap_bound_R6: assert property (@(posedge dco_clk) disable iff (rst)
        tap_code <= TAP_W'(TAP_LAST));

    assert_no_up_at_top_R9: assert property (@(posedge dco_clk) disable iff (rst)
        tap_code == TAP_W'(TAP_LAST) |-> !tap_up);
endmodule

bind fll_dco_ctrl fll_dco_ctrl_chk i_fll_dco_ctrl_chk (
    .dco_clk     (dco_clk),
    .ref_clk     (ref_clk),
    .rst         (rst),
    .integ_clr   (integ_clr),
    .integ_value (integ_value),
    .tap_code    (tap_code),
    .tap_up      (tap_up)
);

// File: tb/test_fll_dco_ctrl.sv
`timescale 1ns/1ps
module test_fll_dco_ctrl;
    logic       dco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] ratio_mult = 7'd0;
    logic [1:0] ratio_dsel = 2'd0;
    logic       ratio_bypass = 1'b0;
    logic       integ_clr = 1'b0;
    logic [9:0] integ_value;
    logic [4:0] tap_code;
    logic       tap_up;

    int  ref_half = 80;   // ns; 80 -> 20 oscillator cycles per period, 800 -> 200
    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    fll_dco_ctrl i_fll_dco_ctrl (
        .dco_clk      (dco_clk),
        .ref_clk      (ref_clk),
        .rst          (rst),
        .ratio_mult   (ratio_mult),
        .ratio_dsel   (ratio_dsel),
        .ratio_bypass (ratio_bypass),
        .integ_clr    (integ_clr),
        .integ_value  (integ_value),
        .tap_code     (tap_code),
        .tap_up       (tap_up)
    );

    always #4 dco_clk = ~dco_clk;   // 125 MHz

    initial begin
        #1;
        forever begin
            #(ref_half) ref_clk = ~ref_clk;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int target_of(int n, int d, int b);
        return (b != 0) ? ((n + 1) << d) : (n + 1);
    endfunction

    function automatic int cycles_per_period();
        return (2 * ref_half) / 8;
    endfunction

    task automatic set_cfg(int n, int d, int b);
        ratio_mult   = 7'(n);
        ratio_dsel   = 2'(d);
        ratio_bypass = 1'(b);
    endtask

    // One reference period; the integrator must move one step in the given direction
    task automatic run_periods(int n, bit up, string req);
        for (int i = 0; i < n; i++) begin
            int prev;
            int exp;
            prev = int'(integ_value);
            @(negedge ref_clk);
            if (up) exp = (prev == 1023) ? 1023 : prev + 1;
            else    exp = (prev == 0) ? 0 : prev - 1;
            check(int'(integ_value) == exp, req, int'(integ_value), exp);
        end
    endtask

    // Tap code and tap+1 density for the value held during this period
    task automatic mod_check();
        int v;
        int et;
        int em;
        int n32;
        int n16;
        @(negedge ref_clk);
        v  = int'(integ_value);
        et = ((v >> 5) > 28) ? 28 : (v >> 5);
        em = ((v >> 5) >= 28) ? 0 : (v & 31);
        @(negedge dco_clk);
        check(int'(tap_code) == et, "R6", int'(tap_code), et);
        n32 = 0;
        for (int i = 0; i < 32; i++) begin
            if (tap_up) n32++;
            @(negedge dco_clk);
        end
        if ((v >> 5) >= 28) check(n32 == 0, "R9", n32, 0);
        else                check(n32 == em, "R7", n32, em);
        n16 = 0;
        for (int i = 0; i < 16; i++) begin
            if (tap_up) n16++;
            @(negedge dco_clk);
        end
        check(n16 == em / 2 || n16 == (em + 1) / 2, "R8", n16, em / 2);
    endtask

    initial begin
        // R1: reset state
        set_cfg(127, 3, 1);   // target 1024: always up
        repeat (3) @(posedge ref_clk);
        @(negedge ref_clk);
        #2 rst = 1'b0;
        @(negedge dco_clk);
        check(int'(integ_value) == 0, "R1", int'(integ_value), 0);
        check(int'(tap_code) == 0, "R1", int'(tap_code), 0);
        check(tap_up == 1'b0, "R1", int'(tap_up), 0);

        // warm-up, then steady upward stepping (R3)
        repeat (6) @(negedge ref_clk);
        run_periods(10, 1'b1, "R3");

        // R2: every divider/bypass combination around the measured count of 20
        for (int b = 0; b < 2; b++) begin
            for (int d = 0; d < 4; d++) begin
                for (int k = 0; k < 6; k++) begin
                    int n;
                    int t;
                    case (k)
                        0: n = 0;
                        1: n = 4;
                        2: n = 9;
                        3: n = 19;
                        4: n = 20;
                        default: n = 127;
                    endcase
                    t = target_of(n, d, b);
                    set_cfg(n, d, b);
                    repeat (2) @(negedge ref_clk);
                    run_periods(1, cycles_per_period() < t, "R2");
                end
            end
        end

        // R5: clear, then stepping resumes from zero
        set_cfg(127, 3, 1);
        repeat (2) @(negedge ref_clk);
        integ_clr = 1'b1;
        @(negedge ref_clk);
        integ_clr = 1'b0;
        check(int'(integ_value) == 0, "R5", int'(integ_value), 0);
        @(negedge ref_clk);
        check(int'(integ_value) == 1, "R5", int'(integ_value), 1);

        // R6..R8 over the low taps with long periods
        ref_half = 800;
        repeat (2) @(negedge ref_clk);
        for (int i = 0; i < 70; i++) mod_check();

        // climb near the clamp, then check across tap 27 -> 28
        ref_half = 80;
        while (int'(integ_value) < 860) @(negedge ref_clk);
        ref_half = 800;
        @(negedge ref_clk);
        for (int i = 0; i < 40; i++) mod_check();

        // R4: ceiling
        ref_half = 80;
        while (int'(integ_value) < 1023) @(negedge ref_clk);
        run_periods(5, 1'b1, "R4");
        mod_check();

        // R2: stepping down from the ceiling with target 1
        set_cfg(0, 0, 0);
        @(negedge ref_clk);
        run_periods(3, 1'b0, "R2");

        // R4: floor
        integ_clr = 1'b1;
        @(negedge ref_clk);
        integ_clr = 1'b0;
        run_periods(4, 1'b0, "R4");
        mod_check();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", int'(integ_value), 1023);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule